// File: doc/BRIEF.md
# Page Access Permission Checker

This block decides whether a memory access that has already been translated breaks the protection rules of a two-level paging scheme. For each request it gets the kind of access (data read, data write or instruction fetch), the privilege context it was issued from, a handful of control enables, and the permission bits of the directory entry and the table entry that mapped the address. It then reports, one cycle later, whether a page fault must be raised and the error code that goes with it.

Three privilege contexts are understood: user, supervisor, and a supervisor context that is allowed to touch user-accessible data (it bypasses only the supervisor data-access guard). Two supervisor guards can be turned on: one stops the supervisor from executing code in user-accessible pages, the other stops plain supervisor data accesses to user-accessible pages. The block does no table walking and keeps no translation state; it is a pure per-request decision with a single output register stage.

Top module: `pgchk_top`

## Requirements
- R1: Encodings: `acc_kind` 0 = read, 1 = write, 2 = fetch, 3 = read; `priv_ctx` 0 = user, 1 = supervisor, 2 = supervisor with data-guard override, 3 = unused. A fetch faults in every context when the effective no-execute bit is set and both `nxe_en` and `pae_en` are 1; with either enable at 0 the no-execute bit is ignored.
- R2: In user context a request faults when the effective user bit is 0, or when it is a write and the effective writable bit is 0.
- R3: In supervisor context (1) with `smap_en` set, any read or write (not a fetch) to an entry whose effective user bit is 1 faults.
- R4: The override context (2) never faults because of `smap_en`, but applies all other supervisor rules.
- R5: In contexts 1 and 2 with `smep_en` set, a fetch from an entry whose effective user bit is 1 faults.
- R6: In contexts 1 and 2 a write to an entry whose effective writable bit is 0 faults only when `wp_en` is 1.
- R7: For small pages (`large_page` = 0) the effective user and writable bits are the AND of the directory and table bits and the effective no-execute bit is their OR; for large pages the directory bits alone are used and the table bits have no effect.
- R8: On a fault, `err_code` bit 0 is 1, bit 1 is 1 for a write, bit 2 is 1 for user context, bit 4 is 1 for a fetch when (`nxe_en` and `pae_en`) or `smep_en`; all other bits are 0. When no fault is reported, `err_code` is all zero.
- R9: `fault`, `err_code` and `out_valid` are registered: a request with `in_valid` = 1 is answered on the next clock edge with `out_valid` = 1 for exactly one cycle; without `in_valid`, `out_valid` drops and `fault`/`err_code` keep their last value.
- R10: Context 3 applies no privilege rule; only the no-execute fetch rule of R1 can fault it.
- R11: While `rst` is 1, `out_valid`, `fault` and `err_code` are cleared on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| acc_kind | input | 2 | Access kind code |
| priv_ctx | input | 2 | Privilege context code |
| smep_en | input | 1 | Supervisor execute guard enable |
| smap_en | input | 1 | Supervisor data guard enable |
| wp_en | input | 1 | Supervisor write-protect enable |
| nxe_en | input | 1 | No-execute enable |
| pae_en | input | 1 | Extended entry format enable |
| dir_user | input | 1 | Directory entry user bit |
| dir_rw | input | 1 | Directory entry writable bit |
| dir_nx | input | 1 | Directory entry no-execute bit |
| tbl_user | input | 1 | Table entry user bit |
| tbl_rw | input | 1 | Table entry writable bit |
| tbl_nx | input | 1 | Table entry no-execute bit |
| large_page | input | 1 | Mapping is a large page |
| out_valid | output | 1 | Result strobe |
| fault | output | 1 | Protection fault |
| err_code | output | ERR_W | Page-fault error code |

## Verification
The bench builds the block with the default `ERR_W` of 16, so the eleven code bits above the defined fields are observable and each fault checks that they stay zero. With that width every combination of context, access kind, enables and entry bits fits a random request, and the directed cases pin the guard interactions (override against the data guard, write-protect on and off, table bits under a large page) against a reference function.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;

    typedef enum logic [1:0] {
        ACC_READ     = 2'd0,
        ACC_WRITE    = 2'd1,
        ACC_FETCH    = 2'd2,
        ACC_READ_ALT = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CTX_USER      = 2'd0,
        CTX_SUPER     = 2'd1,
        CTX_SUPER_OVR = 2'd2,
        CTX_NONE      = 2'd3
    } priv_ctx_e;

    typedef struct packed {
        logic user;
        logic rw;
        logic nx;
    } perm_t;

    typedef struct packed {
        logic smep;
        logic smap;
        logic wp;
        logic nxe;
        logic pae;
    } ctl_t;

    localparam int unsigned ERR_BIT_P   = 0;
    localparam int unsigned ERR_BIT_W   = 1;
    localparam int unsigned ERR_BIT_U   = 2;
    localparam int unsigned ERR_BIT_RSV = 3;
    localparam int unsigned ERR_BIT_ID  = 4;
    localparam int unsigned ERR_MIN_W   = 5;

    function automatic logic is_fetch(input acc_kind_e k);
        return k == ACC_FETCH;
    endfunction

    function automatic logic is_write(input acc_kind_e k);
        return k == ACC_WRITE;
    endfunction

    function automatic logic is_data(input acc_kind_e k);
        return k != ACC_FETCH;
    endfunction

    function automatic logic is_supervisor(input priv_ctx_e c);
        return (c == CTX_SUPER) || (c == CTX_SUPER_OVR);
    endfunction

endpackage

// File: rtl/pgchk_perm_merge.sv
module pgchk_perm_merge
    import pgchk_pkg::*;
(
    input  perm_t dir_perm,
    input  perm_t tbl_perm,
    input  logic  large_page,
    output perm_t eff_perm
);
    always_comb begin
        if (large_page) begin
            eff_perm = dir_perm;
        end else begin
            eff_perm.user = dir_perm.user & tbl_perm.user;
            eff_perm.rw   = dir_perm.rw   & tbl_perm.rw;
            eff_perm.nx   = dir_perm.nx   | tbl_perm.nx;
        end
    end
endmodule

// File: rtl/pgchk_rules.sv
module pgchk_rules
    import pgchk_pkg::*;
(
    input  acc_kind_e kind,
    input  priv_ctx_e ctx,
    input  ctl_t      ctl,
    input  perm_t     eff,
    output logic      fault
);
    logic nx_hit;
    logic user_hit;
    logic super_hit;

    // No-execute rule applies in every context.
    assign nx_hit = is_fetch(kind) && ctl.nxe && ctl.pae && eff.nx;

    always_comb begin
        user_hit = 1'b0;
        if (ctx == CTX_USER) begin
            if (!eff.user) user_hit = 1'b1;
            if (is_write(kind) && !eff.rw) user_hit = 1'b1;
        end
    end

    always_comb begin
        super_hit = 1'b0;
        if (is_supervisor(ctx)) begin
            if (ctx == CTX_SUPER && ctl.smap && is_data(kind) && eff.user)
                super_hit = 1'b1;
            if (ctl.smep && is_fetch(kind) && eff.user)
                super_hit = 1'b1;
            if (ctl.wp && is_write(kind) && !eff.rw)
                super_hit = 1'b1;
        end
    end

    assign fault = nx_hit | user_hit | super_hit;
endmodule

// File: rtl/pgchk_errcode.sv
module pgchk_errcode
    import pgchk_pkg::*;
#(
    parameter int unsigned ERR_W = 16
) (
    input  logic             fault,
    input  acc_kind_e        kind,
    input  priv_ctx_e        ctx,
    input  ctl_t             ctl,
    output logic [ERR_W-1:0] code
);
    logic [ERR_MIN_W-1:0] base;

    always_comb begin
        base              = '0;
        base[ERR_BIT_P]   = fault;
        base[ERR_BIT_W]   = fault && is_write(kind);
        base[ERR_BIT_U]   = fault && (ctx == CTX_USER);
        base[ERR_BIT_RSV] = 1'b0;
        base[ERR_BIT_ID]  = fault && is_fetch(kind) &&
                            ((ctl.nxe && ctl.pae) || ctl.smep);
    end

    for (genvar i = 0; i < int'(ERR_W); i++) begin : g_bit
        if (i < int'(ERR_MIN_W)) begin : g_def
            assign code[i] = base[i];
        end else begin : g_pad
            assign code[i] = 1'b0;
        end
    end
endmodule

// File: rtl/pgchk_top.sv
module pgchk_top
    import pgchk_pkg::*;
#(
    parameter int unsigned ERR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       acc_kind,
    input  logic [1:0]       priv_ctx,
    input  logic             smep_en,
    input  logic             smap_en,
    input  logic             wp_en,
    input  logic             nxe_en,
    input  logic             pae_en,
    input  logic             dir_user,
    input  logic             dir_rw,
    input  logic             dir_nx,
    input  logic             tbl_user,
    input  logic             tbl_rw,
    input  logic             tbl_nx,
    input  logic             large_page,
    output logic             out_valid,
    output logic             fault,
    output logic [ERR_W-1:0] err_code
);
    acc_kind_e        kind;
    priv_ctx_e        ctx;
    ctl_t             ctl;
    perm_t            dir_perm;
    perm_t            tbl_perm;
    perm_t            eff_perm;
    logic             fault_c;
    logic [ERR_W-1:0] code_c;

    assign kind     = acc_kind_e'(acc_kind);
    assign ctx      = priv_ctx_e'(priv_ctx);
    assign ctl      = '{smep: smep_en, smap: smap_en, wp: wp_en,
                        nxe: nxe_en, pae: pae_en};
    assign dir_perm = '{user: dir_user, rw: dir_rw, nx: dir_nx};
    assign tbl_perm = '{user: tbl_user, rw: tbl_rw, nx: tbl_nx};

    pgchk_perm_merge merge_i (
        .dir_perm   (dir_perm),
        .tbl_perm   (tbl_perm),
        .large_page (large_page),
        .eff_perm   (eff_perm)
    );

    pgchk_rules rules_i (
        .kind  (kind),
        .ctx   (ctx),
        .ctl   (ctl),
        .eff   (eff_perm),
        .fault (fault_c)
    );

    pgchk_errcode #(.ERR_W(ERR_W)) code_i (
        .fault (fault_c),
        .kind  (kind),
        .ctx   (ctx),
        .ctl   (ctl),
        .code  (code_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            fault     <= 1'b0;
            err_code  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                fault    <= fault_c;
                err_code <= code_c;
            end
        end
    end
endmodule

// File: rtl/pgchk_checker.sv
module pgchk_checker #(
    parameter int unsigned ERR_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       acc_kind,
    input logic [1:0]       priv_ctx,
    input logic             smep_en,
    input logic             smap_en,
    input logic             nxe_en,
    input logic             pae_en,
    input logic             dir_user,
    input logic             dir_nx,
    input logic             tbl_user,
    input logic             tbl_nx,
    input logic             large_page,
    input logic             out_valid,
    input logic             fault,
    input logic [ERR_W-1:0] err_code
);
    logic user_e;
    logic nx_e;
    assign user_e = large_page ? dir_user : (dir_user & tbl_user);
    assign nx_e   = large_page ? dir_nx   : (dir_nx | tbl_nx);

    assert_nx_fetch_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid && acc_kind == 2'd2 && nxe_en && pae_en && nx_e |=> fault);

    assert_smap_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid && priv_ctx == 2'd1 && smap_en && acc_kind != 2'd2 && user_e
        |=> fault);

    assert_smep_R5: assert property (@(posedge clk) disable iff (rst)
        in_valid && (priv_ctx == 2'd1 || priv_ctx == 2'd2) && acc_kind == 2'd2
        && smep_en && user_e |=> fault);

    assert_fault_present_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid && fault |-> err_code[0]);

    assert_clear_code_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !fault |-> err_code == '0);

    assert_user_bit_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!fault || (err_code[2] == $past(priv_ctx == 2'd0))));

    assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_drop_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(fault) && $stable(err_code));

    assert_reset_R11: assert property (@(posedge clk)
        rst |=> !out_valid && !fault);
endmodule

bind pgchk_top pgchk_checker #(.ERR_W(ERR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .acc_kind   (acc_kind),
    .priv_ctx   (priv_ctx),
    .smep_en    (smep_en),
    .smap_en    (smap_en),
    .nxe_en     (nxe_en),
    .pae_en     (pae_en),
    .dir_user   (dir_user),
    .dir_nx     (dir_nx),
    .tbl_user   (tbl_user),
    .tbl_nx     (tbl_nx),
    .large_page (large_page),
    .out_valid  (out_valid),
    .fault      (fault),
    .err_code   (err_code)
);

// File: tb/pgchk_top_tb_top.sv
module pgchk_top_tb_top;
    localparam int unsigned ERR_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [1:0] acc_kind = '0;
    logic [1:0] priv_ctx = '0;
    logic smep_en = 0, smap_en = 0, wp_en = 0, nxe_en = 0, pae_en = 0;
    logic dir_user = 0, dir_rw = 0, dir_nx = 0;
    logic tbl_user = 0, tbl_rw = 0, tbl_nx = 0;
    logic large_page = 0;
    logic out_valid;
    logic fault;
    logic [ERR_W-1:0] err_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pgchk_top #(.ERR_W(ERR_W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .acc_kind(acc_kind), .priv_ctx(priv_ctx),
        .smep_en(smep_en), .smap_en(smap_en), .wp_en(wp_en),
        .nxe_en(nxe_en), .pae_en(pae_en),
        .dir_user(dir_user), .dir_rw(dir_rw), .dir_nx(dir_nx),
        .tbl_user(tbl_user), .tbl_rw(tbl_rw), .tbl_nx(tbl_nx),
        .large_page(large_page),
        .out_valid(out_valid), .fault(fault), .err_code(err_code)
    );

    // Reference decision written from the requirements.
    function automatic logic ref_fault();
        logic u, w, x, fetch, wr, f;
        u = large_page ? dir_user : (dir_user & tbl_user);
        w = large_page ? dir_rw   : (dir_rw & tbl_rw);
        x = large_page ? dir_nx   : (dir_nx | tbl_nx);
        fetch = (acc_kind == 2'd2);
        wr    = (acc_kind == 2'd1);
        f = fetch && nxe_en && pae_en && x;                  // R1
        if (priv_ctx == 2'd0) begin                          // R2
            if (!u || (wr && !w)) f = 1'b1;
        end else if (priv_ctx == 2'd1 || priv_ctx == 2'd2) begin
            if (priv_ctx == 2'd1 && smap_en && !fetch && u) f = 1'b1; // R3, R4
            if (smep_en && fetch && u) f = 1'b1;                      // R5
            if (wp_en && wr && !w) f = 1'b1;                          // R6
        end
        return f;                                            // R10: ctx 3 adds nothing
    endfunction

    function automatic logic [ERR_W-1:0] ref_code(input logic f);
        logic [ERR_W-1:0] c;
        c = '0;
        if (f) begin                                         // R8
            c[0] = 1'b1;
            c[1] = (acc_kind == 2'd1);
            c[2] = (priv_ctx == 2'd0);
            c[4] = (acc_kind == 2'd2) && ((nxe_en && pae_en) || smep_en);
        end
        return c;
    endfunction

    task automatic check(input string tag, input logic v, input logic f,
                         input logic [ERR_W-1:0] c);
        checks++;
        if (out_valid !== v || fault !== f || err_code !== c) begin
            errors++;
            $display("FAIL %s: got valid=%0b fault=%0b code=%h, expected valid=%0b fault=%0b code=%h",
                     tag, out_valid, fault, err_code, v, f, c);
        end
    endtask

    task automatic set_stim(input logic [1:0] k, input logic [1:0] c,
                            input logic smep, input logic smap, input logic wp,
                            input logic nxe, input logic pae,
                            input logic du, input logic drw, input logic dnx,
                            input logic tu, input logic trw, input logic tnx,
                            input logic lg);
        acc_kind = k; priv_ctx = c;
        smep_en = smep; smap_en = smap; wp_en = wp; nxe_en = nxe; pae_en = pae;
        dir_user = du; dir_rw = drw; dir_nx = dnx;
        tbl_user = tu; tbl_rw = trw; tbl_nx = tnx; large_page = lg;
    endtask

    // Drives one request (stimulus already set) and checks the answer.
    task automatic run_one(input string tag, input logic ef,
                           input logic [ERR_W-1:0] ec);
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, 1'b1, ef, ec);
    endtask

    function automatic string tag_of();
        case (priv_ctx)
            2'd0:    return "R2";
            2'd1:    return "R3";
            2'd2:    return "R4";
            default: return "R10";
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset", 1'b0, 1'b0, '0);
        rst = 1'b0;

        // R2: small page, table user bit clear
        set_stim(2'd0, 2'd0, 0,0,0,0,0, 1,1,0, 0,1,0, 0);
        run_one("R2 user bit", 1'b1, 16'h0005);
        // R7: same bits, large page ignores table
        large_page = 1'b1;
        run_one("R7 large page", 1'b0, 16'h0000);
        // R9: idle cycle, valid drops, result held
        @(negedge clk);
        check("R9 hold", 1'b0, 1'b0, 16'h0000);
        // R2: user write to read-only
        set_stim(2'd1, 2'd0, 0,0,0,0,0, 1,1,0, 1,0,0, 0);
        run_one("R2 write ro", 1'b1, 16'h0007);
        @(negedge clk);
        check("R9 hold fault", 1'b0, 1'b1, 16'h0007);
        // R3: supervisor read of user page with data guard
        set_stim(2'd0, 2'd1, 0,1,0,0,0, 1,1,0, 1,1,0, 0);
        run_one("R3 smap read", 1'b1, 16'h0001);
        acc_kind = 2'd3;
        run_one("R3 smap read alt", 1'b1, 16'h0001);
        // R4: override context bypasses data guard
        acc_kind = 2'd1; priv_ctx = 2'd2;
        run_one("R4 override write", 1'b0, 16'h0000);
        // R5: execute guard in both supervisor contexts
        set_stim(2'd2, 2'd1, 1,0,0,0,0, 1,1,0, 1,1,0, 0);
        run_one("R5 smep super", 1'b1, 16'h0011);
        priv_ctx = 2'd2;
        run_one("R5 smep override", 1'b1, 16'h0011);
        // R6: write-protect off then on
        set_stim(2'd1, 2'd1, 0,0,0,0,0, 0,0,0, 0,0,0, 0);
        run_one("R6 wp off", 1'b0, 16'h0000);
        wp_en = 1'b1;
        run_one("R6 wp on", 1'b1, 16'h0003);
        // R1: no-execute fetch with both enables, then with one off
        set_stim(2'd2, 2'd0, 0,0,0,1,1, 1,1,1, 1,1,0, 0);
        run_one("R1 nx fetch", 1'b1, 16'h0015);
        pae_en = 1'b0;
        run_one("R1 nx ignored", 1'b0, 16'h0000);
        // R7: nx only in table, small page
        set_stim(2'd2, 2'd1, 0,0,0,1,1, 0,1,0, 0,1,1, 0);
        run_one("R7 table nx", 1'b1, 16'h0011);
        large_page = 1'b1;
        run_one("R7 table nx large", 1'b0, 16'h0000);
        // R10: unused context
        set_stim(2'd1, 2'd3, 1,1,1,0,0, 1,0,0, 1,0,0, 0);
        run_one("R10 no privilege rule", 1'b0, 16'h0000);
        set_stim(2'd2, 2'd3, 0,0,0,1,1, 1,1,1, 1,1,1, 1);
        run_one("R10 nx still applies", 1'b1, 16'h0011);
        // R8: fetch fault with no enables has no fetch bit
        set_stim(2'd2, 2'd0, 0,0,0,0,0, 0,1,0, 0,1,0, 0);
        run_one("R8 no id bit", 1'b1, 16'h0005);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            logic ef;
            r = $urandom();
            set_stim(r[1:0] == 2'd3 ? 2'd2 : r[1:0], r[3:2],
                     r[4], r[5], r[6], r[7], r[8],
                     r[9], r[10], r[11], r[12], r[13], r[14], r[15]);
            ef = ref_fault();
            run_one(tag_of(), ef, ref_code(ef));
            if (r[16]) begin
                @(negedge clk);
                check("R9 idle", 1'b0, ef, ref_code(ef));
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got running, expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule